// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital control stage that sits between the regulation loop of a synchronous step-down converter and its two gate drivers. Each clock it reads a pulse-width request, two window-override flags, a fault flag, a negative-current flag and a bootstrap-health flag. From these it produces a high-side gate level and a low-side gate level.

Two static configuration bits choose the high-side switch type and the conduction mode. For an N-channel switch the high-side gate is active high. For a P-channel switch it is active low. In continuous mode the low-side switch conducts whenever the high side is off. In discontinuous mode the low side is cut off as soon as the inductor current reverses, and it stays off until the next high-side pulse.

The sequencer never turns on a gate until both gates have been off for a programmable dead time. It holds every high-side pulse for a programmable minimum width. In N-channel mode, when the bootstrap supply is weak, it stretches the following low-side interval so that the bootstrap capacitor can recharge. A fault removes both gates on the next clock edge.

Top module: `buck_gate_ctrl`

## Requirements
- R1: `cfg_pch`=0 selects an N-channel high side, for which `hs_gate`=1 means on. `cfg_pch`=1 selects a P-channel high side, for which `hs_gate`=0 means on. `ls_gate` is always active high. `cfg_dcm`=0 selects continuous conduction and `cfg_dcm`=1 selects discontinuous conduction.
- R2: When `fault` is sampled high, both gates are off after that same clock edge and stay off while it remains high. A fault also cancels any pending stretched low-side interval.
- R3: The high side is requested when `win_lo`=1, or when `pwm_req`=1 and `win_hi`=0. While it is requested, the low side turns off on the first edge and the high side follows after the dead time.
- R4: In continuous mode, while the high side is not requested, the low side is on. This also holds after reset: it turns on DEAD_CYC+1 edges after reset is released.
- R5: Between one gate turning off and either gate turning on, both gates are off for at least DEAD_CYC clock cycles, and exactly DEAD_CYC cycles on a normal hand-over.
- R6: Unless a fault intervenes, a high-side pulse lasts at least MINHI_CYC cycles, even if the request drops earlier.
- R7: In discontinuous mode, `zc_neg` passes through SYNC_STAGES synchroniser flops. A high level therefore turns the low side off SYNC_STAGES+1 edges after it is applied. The low side then stays off until a high-side pulse has occurred. In continuous mode, `zc_neg` has no effect.
- R8: In N-channel mode, if `boot_ok` is low at the edge where the high side turns off, the next low-side interval lasts at least FORCE_CYC cycles, even against a high-side request. In P-channel mode, `boot_ok` has no effect.
- R9: During reset both gates are at their off level, with `hs_gate` equal to `cfg_pch`.
- R10: The two switches are never on in the same cycle, and neither turns on in the cycle right after the other was on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pch | input | 1 | High-side switch type: 0 = N-channel, 1 = P-channel |
| cfg_dcm | input | 1 | Conduction mode: 0 = continuous, 1 = discontinuous |
| pwm_req | input | 1 | Main-loop request: 1 = high side on |
| win_lo | input | 1 | Output below window: forces the high-side request |
| win_hi | input | 1 | Output above window: suppresses the PWM request |
| fault | input | 1 | Fault flag: both gates off |
| zc_neg | input | 1 | Asynchronous flag: inductor current negative |
| boot_ok | input | 1 | Bootstrap supply adequate |
| hs_gate | output | 1 | High-side gate level, polarity set by cfg_pch |
| ls_gate | output | 1 | Low-side gate level, active high |

## Verification
The bench builds the block with DEAD_CYC=3, MINHI_CYC=4, FORCE_CYC=6 and SYNC_STAGES=2. These values differ from one another, so an off-by-one in any single counter shifts one measured edge count and cannot be masked by another counter. They also keep every gap, minimum pulse and stretched interval short enough to be timed edge by edge. The hand-over gap, the minimum pulse width, the stretched low-side interval and the synchroniser latency are each measured as exact cycle counts from the stimulus edge. They are measured in both switch polarities and in both conduction modes.

// File: rtl/buck_gd_pkg.sv
package buck_gd_pkg;

  // Sequencer phases; exactly one gate may be on, and only in ST_HIGH / ST_LOW.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,  // both off, waiting for a reason to turn one on
    ST_GAP_HI = 3'd1,  // dead time ahead of a high-side turn-on
    ST_HIGH   = 3'd2,  // high-side switch conducting
    ST_GAP_LO = 3'd3,  // dead time ahead of a low-side turn-on
    ST_LOW    = 3'd4   // low-side switch conducting
  } seq_state_t;

  // Width of a counter that must reach the largest of three limits.
  function automatic int cnt_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/buck_zc_sync.sv
module buck_zc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff <= '0;
    end else begin
      ff[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        ff[i] <= ff[i-1];
      end
    end
  end

  assign q = ff[STAGES-1];

endmodule

// File: rtl/buck_seq_fsm.sv
module buck_seq_fsm
  import buck_gd_pkg::*;
#(
  parameter int DEAD_CYC  = 15,
  parameter int MINHI_CYC = 40,
  parameter int FORCE_CYC = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic want_hi,
  input  logic dcm,
  input  logic pch,
  input  logic boot_ok,
  input  logic zc_now,
  output logic hs_nx,
  output logic ls_nx
);

  localparam int CW = cnt_width(DEAD_CYC, MINHI_CYC, FORCE_CYC);
  localparam logic [CW-1:0] DEAD_LAST  = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] MINHI_LAST = CW'(MINHI_CYC - 1);
  localparam logic [CW-1:0] FORCE_LAST = CW'(FORCE_CYC - 1);
  localparam logic [CW-1:0] CNT_TOP    = {CW{1'b1}};

  seq_state_t st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic force_q, force_n;  // stretched low-side interval pending/active
  logic hold_q, hold_n;    // low side barred until next high-side pulse

  logic gap_done, hi_min_met, lo_min_met;

  assign gap_done   = (cnt_q >= DEAD_LAST);
  assign hi_min_met = (cnt_q >= MINHI_LAST);
  assign lo_min_met = !force_q || (cnt_q >= FORCE_LAST);

  always_comb begin
    st_n    = st_q;
    force_n = force_q;
    hold_n  = hold_q;
    case (st_q)
      ST_IDLE: begin
        if (want_hi) begin
          st_n = ST_GAP_HI;
        end else if (!dcm || !hold_q) begin
          st_n = ST_GAP_LO;
        end
      end
      ST_GAP_HI: begin
        if (gap_done) begin
          st_n   = ST_HIGH;
          hold_n = 1'b0;
        end
      end
      ST_HIGH: begin
        if (!want_hi && hi_min_met) begin
          st_n    = ST_GAP_LO;
          force_n = !pch && !boot_ok;
        end
      end
      ST_GAP_LO: begin
        if (gap_done) begin
          if (!dcm || force_q || !hold_q) begin
            st_n = ST_LOW;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_LOW: begin
        if (lo_min_met) begin
          if (want_hi) begin
            st_n    = ST_GAP_HI;
            force_n = 1'b0;
          end else if (dcm && zc_now) begin
            st_n    = ST_IDLE;
            hold_n  = 1'b1;
            force_n = 1'b0;
          end
        end
      end
      default: begin
        st_n = ST_IDLE;
      end
    endcase
    if (fault) begin
      st_n    = ST_IDLE;
      force_n = 1'b0;
    end
  end

  always_comb begin
    if (st_n != st_q) begin
      cnt_n = '0;
    end else if (cnt_q == CNT_TOP) begin
      cnt_n = cnt_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      force_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      force_q <= force_n;
      hold_q  <= hold_n;
    end
  end

  // Next-cycle gate enables; registered by the output stage.
  assign hs_nx = (st_n == ST_HIGH);
  assign ls_nx = (st_n == ST_LOW);

endmodule

// File: rtl/buck_gate_out.sv
module buck_gate_out (
  input  logic clk,
  input  logic rst,
  input  logic pch,
  input  logic hs_nx,
  input  logic ls_nx,
  output logic hs_gate,
  output logic ls_gate
);

  // A P-channel switch is on with its gate pulled low.
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_gate <= pch;
      ls_gate <= 1'b0;
    end else begin
      hs_gate <= pch ? !hs_nx : hs_nx;
      ls_gate <= ls_nx;
    end
  end

endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl #(
  parameter int DEAD_CYC    = 15,
  parameter int MINHI_CYC   = 40,
  parameter int FORCE_CYC   = 75,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_pch,
  input  logic cfg_dcm,
  input  logic pwm_req,
  input  logic win_lo,
  input  logic win_hi,
  input  logic fault,
  input  logic zc_neg,
  input  logic boot_ok,
  output logic hs_gate,
  output logic ls_gate
);

  logic zc_now;
  logic want_hi;
  logic hs_nx, ls_nx;

  // The below-window flag wins; the above-window flag masks the main loop.
  assign want_hi = win_lo || (pwm_req && !win_hi);

  buck_zc_sync #(
    .STAGES(SYNC_STAGES)
  ) u_zc_sync (
    .clk (clk),
    .rst (rst),
    .d   (zc_neg),
    .q   (zc_now)
  );

  buck_seq_fsm #(
    .DEAD_CYC  (DEAD_CYC),
    .MINHI_CYC (MINHI_CYC),
    .FORCE_CYC (FORCE_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .fault   (fault),
    .want_hi (want_hi),
    .dcm     (cfg_dcm),
    .pch     (cfg_pch),
    .boot_ok (boot_ok),
    .zc_now  (zc_now),
    .hs_nx   (hs_nx),
    .ls_nx   (ls_nx)
  );

  buck_gate_out u_out (
    .clk     (clk),
    .rst     (rst),
    .pch     (cfg_pch),
    .hs_nx   (hs_nx),
    .ls_nx   (ls_nx),
    .hs_gate (hs_gate),
    .ls_gate (ls_gate)
  );

endmodule

// File: rtl/buck_gate_ctrl_chk.sv
module buck_gate_ctrl_chk #(
  parameter int DEAD_CYC  = 15,
  parameter int MINHI_CYC = 40
) (
  input logic clk,
  input logic rst,
  input logic cfg_pch,
  input logic fault,
  input logic hs_gate,
  input logic ls_gate
);

  localparam int LIM = ((DEAD_CYC > MINHI_CYC) ? DEAD_CYC : MINHI_CYC) + 1;
  localparam int CW  = $clog2(LIM + 1);

  logic hs_act, any_on;
  logic [CW-1:0] off_run, hi_run;

  assign hs_act = (hs_gate != cfg_pch);
  assign any_on = hs_act || ls_gate;

  always_ff @(posedge clk) begin
    if (rst || any_on) begin
      off_run <= '0;
    end else if (off_run != {CW{1'b1}}) begin
      off_run <= off_run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !hs_act) begin
      hi_run <= '0;
    end else if (hi_run != {CW{1'b1}}) begin
      hi_run <= hi_run + 1'b1;
    end
  end

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_act && ls_gate));

  // R10
  no_swap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hs_act) |-> !ls_gate) and ($past(ls_gate) |-> !hs_act));

  // R2
  fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> (!hs_act && !ls_gate));

  // R5
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (any_on && !$past(any_on)) |-> (off_run >= CW'(DEAD_CYC)));

  // R6
  min_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hs_act) && !hs_act && !$past(fault)) |-> (hi_run >= CW'(MINHI_CYC)));

endmodule

bind buck_gate_ctrl buck_gate_ctrl_chk #(
  .DEAD_CYC  (DEAD_CYC),
  .MINHI_CYC (MINHI_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_pch (cfg_pch),
  .fault   (fault),
  .hs_gate (hs_gate),
  .ls_gate (ls_gate)
);

// File: tb/buck_gate_ctrl_tb.sv
`timescale 1ns/1ps
module buck_gate_ctrl_tb;

  localparam int D  = 3;
  localparam int MH = 4;
  localparam int F  = 6;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_pch = 1'b0, cfg_dcm = 1'b0;
  logic pwm_req = 1'b0, win_lo = 1'b0, win_hi = 1'b0;
  logic fault = 1'b0, zc_neg = 1'b0, boot_ok = 1'b1;
  logic hs_gate, ls_gate;
  logic hs_on;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  buck_gate_ctrl #(
    .DEAD_CYC(D), .MINHI_CYC(MH), .FORCE_CYC(F), .SYNC_STAGES(SS)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_pch(cfg_pch), .cfg_dcm(cfg_dcm),
    .pwm_req(pwm_req), .win_lo(win_lo), .win_hi(win_hi), .fault(fault),
    .zc_neg(zc_neg), .boot_ok(boot_ok), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  // R1: logical high-side state from the configured polarity
  assign hs_on = hs_gate ^ cfg_pch;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Counts falling edges until the chosen gate reaches the wanted state.
  task automatic wait_for(input bit on_hs, input bit lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while ((((on_hs ? hs_on : ls_gate)) != lvl) && (n < 100));
  endtask

  task automatic do_reset(input bit pch, input bit dcm);
    int n;
    @(negedge clk);
    rst = 1'b1; cfg_pch = pch; cfg_dcm = dcm;
    pwm_req = 1'b0; win_lo = 1'b0; win_hi = 1'b0;
    fault = 1'b0; zc_neg = 1'b0; boot_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_for(1'b0, 1'b1, n);
  endtask

  task automatic t_reset;
    int n;
    rst = 1'b1; cfg_pch = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 n-mode hs_gate in reset", hs_gate, 0);
    chk("R9 ls_gate in reset", ls_gate, 0);
    cfg_pch = 1'b1;
    @(negedge clk);
    chk("R9 p-mode hs_gate in reset", hs_gate, 1);
    cfg_pch = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_for(1'b0, 1'b1, n);
    chk("R4 low side on after reset", n, D + 1);
  endtask

  task automatic t_handover;
    int n;
    do_reset(1'b0, 1'b0);
    pwm_req = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R3 low side off on request", n, 1);
    wait_for(1'b1, 1'b1, n);
    chk("R5 gap before high side", n, D);
    chk("R1 n-mode hs_gate level when on", hs_gate, 1);
    repeat (8) @(negedge clk);
    pwm_req = 1'b0;
    wait_for(1'b1, 1'b0, n);
    chk("R3 high side off on release", n, 1);
    wait_for(1'b0, 1'b1, n);
    chk("R5 gap before low side", n, D);
  endtask

  task automatic t_minhi;
    int n;
    do_reset(1'b0, 1'b0);
    pwm_req = 1'b1;
    wait_for(1'b1, 1'b1, n);
    pwm_req = 1'b0;
    wait_for(1'b1, 1'b0, n);
    chk("R6 minimum high pulse", n, MH);
    wait_for(1'b0, 1'b1, n);
    chk("R4 low side after short pulse", n, D);
  endtask

  task automatic t_window;
    int n;
    do_reset(1'b0, 1'b0);
    win_lo = 1'b1;
    wait_for(1'b1, 1'b1, n);
    chk("R3 below-window forces high", n, D + 1);
    repeat (8) @(negedge clk);
    win_lo = 1'b0; pwm_req = 1'b1; win_hi = 1'b1;
    wait_for(1'b1, 1'b0, n);
    chk("R3 above-window masks pwm", n, 1);
    wait_for(1'b0, 1'b1, n);
    chk("R4 low side under above-window", n, D);
  endtask

  task automatic t_boot;
    int n;
    do_reset(1'b0, 1'b0);
    pwm_req = 1'b1;
    wait_for(1'b1, 1'b1, n);
    repeat (8) @(negedge clk);
    boot_ok = 1'b0; pwm_req = 1'b0;
    wait_for(1'b0, 1'b1, n);
    pwm_req = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R8 stretched low interval", n, F);
    wait_for(1'b1, 1'b1, n);
    repeat (8) @(negedge clk);
    boot_ok = 1'b1; pwm_req = 1'b0;
    wait_for(1'b0, 1'b1, n);
    pwm_req = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R8 no stretch with boot ok", n, 1);
    do_reset(1'b1, 1'b0);
    pwm_req = 1'b1;
    wait_for(1'b1, 1'b1, n);
    chk("R1 p-mode hs_gate level when on", hs_gate, 0);
    repeat (8) @(negedge clk);
    boot_ok = 1'b0; pwm_req = 1'b0;
    wait_for(1'b0, 1'b1, n);
    pwm_req = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R8 p-mode ignores boot_ok", n, 1);
  endtask

  task automatic t_zero_cross;
    int n;
    do_reset(1'b0, 1'b1);
    zc_neg = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R7 negative current cuts low side", n, SS + 1);
    zc_neg = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7 low side held off", ls_gate, 0);
    chk("R7 high side stays off while held", hs_on, 0);
    pwm_req = 1'b1;
    wait_for(1'b1, 1'b1, n);
    chk("R7 high pulse after hold", n, D + 1);
    repeat (8) @(negedge clk);
    pwm_req = 1'b0;
    wait_for(1'b0, 1'b1, n);
    chk("R7 hold cleared by high pulse", n, D + 1);
    do_reset(1'b0, 1'b0);
    zc_neg = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 continuous mode ignores zc_neg", ls_gate, 1);
    zc_neg = 1'b0;
  endtask

  task automatic t_fault;
    int n;
    do_reset(1'b0, 1'b0);
    pwm_req = 1'b1;
    wait_for(1'b1, 1'b1, n);
    repeat (8) @(negedge clk);
    fault = 1'b1;
    wait_for(1'b1, 1'b0, n);
    chk("R2 fault drops high side", n, 1);
    repeat (5) @(negedge clk);
    chk("R2 low side off under fault", ls_gate, 0);
    fault = 1'b0;
    wait_for(1'b1, 1'b1, n);
    chk("R2 restart after fault", n, D + 1);
    repeat (8) @(negedge clk);
    boot_ok = 1'b0; pwm_req = 1'b0;
    wait_for(1'b0, 1'b1, n);
    boot_ok = 1'b1; pwm_req = 1'b1;
    @(negedge clk);
    fault = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R2 fault ends stretched low", n, 1);
    fault = 1'b0; pwm_req = 1'b0;
    wait_for(1'b0, 1'b1, n);
    chk("R4 low side after fault", n, D + 1);
    pwm_req = 1'b1;
    wait_for(1'b0, 1'b0, n);
    chk("R2 stretch cancelled by fault", n, 1);
    do_reset(1'b1, 1'b0);
    pwm_req = 1'b1;
    wait_for(1'b1, 1'b1, n);
    fault = 1'b1;
    @(negedge clk);
    chk("R2 p-mode fault drives hs_gate high", hs_gate, 1);
    fault = 1'b0;
  endtask

  initial begin
    t_reset();
    t_handover();
    t_minhi();
    t_window();
    t_boot();
    t_zero_cross();
    t_fault();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule